// File: doc/BRIEF.md
# Accumulator Math-Error Detector

This block sits beside a 40-bit dual-accumulator arithmetic unit and decides, one cycle after each event, whether a math-error trap must be requested. It looks at the 41-bit result before saturation, which carries one bit beyond the accumulator width. It checks for two kinds of overflow. The first is an ordinary overflow past bit 31, which matters when the upper guard bits are not used. The second is a catastrophic overflow past bit 39, which matters when every form of saturation is off. Each kind has its own enable.

Two further checks are always active. A divide whose divisor is zero is aborted on the next cycle boundary, and a signed shift amount whose magnitude exceeds 16 is flagged. Every detected condition sets a sticky bit in a cause register, and the request always carries trap priority level 11. The cause register also records which accumulator produced the latest overflow. A trap handler reads the cause bits to find out which conditions fired, and clears them with a single-cycle strobe.

Top module: `acc_matherr_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `trap_req`, `div_abort`, `trap_level` and `cause` are all zero.
- R2: A cycle with `div_start` high and `divisor` equal to zero causes `div_abort` and `trap_req` to be high on the following cycle and sets `cause[0]`. A nonzero divisor causes none of these.
- R3: When `op_valid`, `en_ovf31` are high and `guard_en` is low, a result whose bits 39 down to 31 are not all equal raises `trap_req` on the next cycle and sets `cause[1]`. With `guard_en` high, with `en_ovf31` low, or with bits 39 down to 31 all equal, nothing is raised.
- R4: When `op_valid`, `en_ovf39` are high and `sat_en` is low, a result whose bit 40 differs from bit 39 raises `trap_req` on the next cycle and sets `cause[2]`. With `sat_en` high or `en_ovf39` low, nothing is raised.
- R5: A cycle with `shift_stb` high and a two's-complement `shift_amt` greater than 16 or less than -16 raises `trap_req` on the next cycle and sets `cause[3]`. The amounts 16 and -16 are legal.
- R6: `trap_level` equals 11 whenever `trap_req` is high and is 0 otherwise.
- R7: Cause bits 3 down to 0 stay set until a cycle with `cause_clr` high. An event in that same cycle still leaves its bit set afterwards.
- R8: `cause[4]` takes the value of `acc_sel` (1 meaning accumulator B) on every overflow event of either kind. Other events leave it unchanged, and `cause_clr` without an overflow event clears it.
- R9: A result presented while `op_valid` is low has no effect on `trap_req` or `cause`.
- R10: Several conditions in one cycle produce a single one-cycle `trap_req` and set every matching cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An accumulator result is present this cycle |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_result | input | 41 | Pre-saturation result, one bit wider than the accumulator |
| sat_en | input | 1 | Some saturation mode is active |
| guard_en | input | 1 | Accumulator guard bits are in use |
| en_ovf31 | input | 1 | Enable for the bit-31 overflow trap |
| en_ovf39 | input | 1 | Enable for the bit-39 catastrophic overflow trap |
| div_start | input | 1 | A divide begins this cycle |
| divisor | input | 16 | Divisor operand |
| shift_stb | input | 1 | A shift is issued this cycle |
| shift_amt | input | 6 | Signed shift amount |
| cause_clr | input | 1 | Clears the sticky cause register |
| trap_req | output | 1 | One-cycle math-error trap request |
| trap_level | output | 4 | Priority of the request (11) or 0 |
| div_abort | output | 1 | Abort of the divide in progress |
| cause | output | 5 | {acc_b, shift, ovf39, ovf31, div0} sticky flags |

## Verification
The assertions check several rules on every cycle. The first is the fixed level attached to a request. The second is that a request never appears without some cause bit being set. The third is that cause bits stay set while no clear is given. The last is that each overflow detector stays silent while the mode that masks it is active, and that a shift of exactly plus or minus 16 never fires.

Some behaviours can only be shown by the bench scenarios. These are the exact result patterns that count as overflow, the accumulator identifier following the latest overflow, the priority of setting a bit over a clear in the same cycle, and several conditions merging into one request.

// File: rtl/matherr_pkg.sv
package matherr_pkg;
  localparam logic [3:0] MATH_TRAP_LEVEL = 4'd11;

  typedef struct packed {
    logic acc_b;
    logic shift_err;
    logic ovf39;
    logic ovf31;
    logic div0;
  } cause_t;
endpackage

// File: rtl/mx_ovf_detect.sv
module mx_ovf_detect #(
  parameter int ACC_W  = 40,
  parameter int WIN_LO = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [ACC_W:0]   result_hi_ext,
  input  logic             guard_en,
  input  logic             sat_en,
  input  logic             en_ovf31,
  input  logic             en_ovf39,
  output logic             ovf31_evt,
  output logic             ovf39_evt
);
  localparam int SPAN = ACC_W - WIN_LO;

  function automatic logic window_mixed(input logic [ACC_W:0] v);
    logic [SPAN-1:0] win;
    win = v[ACC_W-1:WIN_LO];
    return !((win == '0) || (win == '1));
  endfunction

  function automatic logic carry_past_top(input logic [ACC_W:0] v);
    return v[ACC_W] ^ v[ACC_W-1];
  endfunction

  logic mixed_win;
  logic top_carry;

  assign mixed_win = window_mixed(result_hi_ext);
  assign top_carry = carry_past_top(result_hi_ext);

  assign ovf31_evt = op_valid && en_ovf31 && !guard_en && mixed_win;
  assign ovf39_evt = op_valid && en_ovf39 && !sat_en && top_carry;

  assert_guard_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    guard_en |-> !ovf31_evt);
  assert_sat_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_en |-> !ovf39_evt);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !(ovf31_evt || ovf39_evt));
endmodule

// File: rtl/mx_range_check.sv
module mx_range_check #(
  parameter int DIV_W  = 16,
  parameter int SH_W   = 6,
  parameter int SH_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_start,
  input  logic [DIV_W-1:0] divisor,
  input  logic             shift_stb,
  input  logic [SH_W-1:0]  shift_amt,
  output logic             div0_evt,
  output logic             shift_evt,
  output logic             div_abort
);
  function automatic logic shift_too_far(input logic [SH_W-1:0] a);
    int s;
    s = int'($signed(a));
    return (s > SH_MAX) || (s < -SH_MAX);
  endfunction

  assign div0_evt  = div_start && (divisor == '0);
  assign shift_evt = shift_stb && shift_too_far(shift_amt);

  always_ff @(posedge clk) begin
    if (!rst_n) div_abort <= 1'b0;
    else        div_abort <= div0_evt;
  end

  assert_div_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_start && divisor == '0) |=> div_abort);
  assert_no_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_start |=> !div_abort);
  assert_shift_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && ($signed(shift_amt) == SH_MAX || $signed(shift_amt) == -SH_MAX))
      |-> !shift_evt);
endmodule

// File: rtl/mx_cause_reg.sv
module mx_cause_reg
  import matherr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   div0_evt,
  input  logic   ovf31_evt,
  input  logic   ovf39_evt,
  input  logic   shift_evt,
  input  logic   acc_sel,
  output cause_t cause_q
);
  cause_t cause_d;
  logic   any_ovf;

  assign any_ovf = ovf31_evt || ovf39_evt;

  always_comb begin
    cause_d = clr ? '0 : cause_q;
    cause_d.div0      = cause_d.div0      | div0_evt;
    cause_d.ovf31     = cause_d.ovf31     | ovf31_evt;
    cause_d.ovf39     = cause_d.ovf39     | ovf39_evt;
    cause_d.shift_err = cause_d.shift_err | shift_evt;
    if (any_ovf) cause_d.acc_b = acc_sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause_q[3:0] & $past(cause_q[3:0])) == $past(cause_q[3:0])));
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !any_ovf) |=> $stable(cause_q.acc_b));
endmodule

// File: rtl/acc_matherr_det.sv
module acc_matherr_det
  import matherr_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WIN_LO = 31,
  parameter int DIV_W  = 16,
  parameter int SH_W   = 6,
  parameter int SH_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             acc_sel,
  input  logic [ACC_W:0]   op_result,
  input  logic             sat_en,
  input  logic             guard_en,
  input  logic             en_ovf31,
  input  logic             en_ovf39,
  input  logic             div_start,
  input  logic [DIV_W-1:0] divisor,
  input  logic             shift_stb,
  input  logic [SH_W-1:0]  shift_amt,
  input  logic             cause_clr,
  output logic             trap_req,
  output logic [3:0]       trap_level,
  output logic             div_abort,
  output logic [4:0]       cause
);
  logic   ovf31_evt, ovf39_evt, div0_evt, shift_evt;
  logic   any_evt;
  cause_t cause_q;

  mx_ovf_detect #(.ACC_W(ACC_W), .WIN_LO(WIN_LO)) u_ovf (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .result_hi_ext(op_result),
    .guard_en(guard_en), .sat_en(sat_en), .en_ovf31(en_ovf31), .en_ovf39(en_ovf39),
    .ovf31_evt(ovf31_evt), .ovf39_evt(ovf39_evt)
  );

  mx_range_check #(.DIV_W(DIV_W), .SH_W(SH_W), .SH_MAX(SH_MAX)) u_rng (
    .clk(clk), .rst_n(rst_n), .div_start(div_start), .divisor(divisor),
    .shift_stb(shift_stb), .shift_amt(shift_amt),
    .div0_evt(div0_evt), .shift_evt(shift_evt), .div_abort(div_abort)
  );

  mx_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .clr(cause_clr),
    .div0_evt(div0_evt), .ovf31_evt(ovf31_evt), .ovf39_evt(ovf39_evt),
    .shift_evt(shift_evt), .acc_sel(acc_sel), .cause_q(cause_q)
  );

  assign any_evt = div0_evt || ovf31_evt || ovf39_evt || shift_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) trap_req <= 1'b0;
    else        trap_req <= any_evt;
  end

  assign trap_level = trap_req ? MATH_TRAP_LEVEL : 4'd0;
  assign cause      = cause_q;

  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_level == 4'd11));
  assert_level_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (trap_level == 4'd0));
  assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (|cause[3:0]));
  assert_abort_traps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_abort |-> trap_req);
endmodule

// File: tb/acc_matherr_det_tb.sv
module acc_matherr_det_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, acc_sel = 0, sat_en = 0, guard_en = 0;
  logic        en_ovf31 = 0, en_ovf39 = 0, div_start = 0, shift_stb = 0, cause_clr = 0;
  logic [40:0] op_result = '0;
  logic [15:0] divisor = 16'd1;
  logic [5:0]  shift_amt = '0;
  logic        trap_req, div_abort;
  logic [3:0]  trap_level;
  logic [4:0]  cause;

  int    checks = 0, failures = 0;
  string cur_req = "R1";

  logic       m_trap = 0, m_abort = 0;
  logic [4:0] m_cause = '0;

  acc_matherr_det u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .acc_sel(acc_sel),
    .op_result(op_result), .sat_en(sat_en), .guard_en(guard_en),
    .en_ovf31(en_ovf31), .en_ovf39(en_ovf39), .div_start(div_start),
    .divisor(divisor), .shift_stb(shift_stb), .shift_amt(shift_amt),
    .cause_clr(cause_clr), .trap_req(trap_req), .trap_level(trap_level),
    .div_abort(div_abort), .cause(cause)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    bit e_div, e31, e39, e_sh;
    int hi9, sa;
    hi9 = int'(op_result[39:31]);
    sa  = shift_amt[5] ? int'(shift_amt) - 64 : int'(shift_amt);
    e_div = div_start && divisor == 0;
    e31   = op_valid && en_ovf31 && !guard_en && !(hi9 == 0 || hi9 == 511);
    e39   = op_valid && en_ovf39 && !sat_en && (op_result[40] != op_result[39]);
    e_sh  = shift_stb && (sa > 16 || sa < -16);
    if (!rst_n) begin
      m_trap = 0; m_abort = 0; m_cause = 0;
    end else begin
      m_trap  = e_div | e31 | e39 | e_sh;
      m_abort = e_div;
      if (cause_clr) m_cause = 0;
      m_cause[0] |= e_div;
      m_cause[1] |= e31;
      m_cause[2] |= e39;
      m_cause[3] |= e_sh;
      if (e31 || e39) m_cause[4] = acc_sel;
    end
    #2;
    chk(cur_req, trap_req, m_trap, "trap_req");
    chk("R6", trap_level, m_trap ? 11 : 0, "trap_level");
    chk(cur_req, div_abort, m_abort, "div_abort");
    chk(cur_req, cause, m_cause, "cause");
  end

  task automatic idle;
    op_valid = 0; div_start = 0; shift_stb = 0; cause_clr = 0;
  endtask

  task automatic tick;
    @(negedge clk);
    idle();
  endtask

  task automatic clear_all;
    cause_clr = 1; tick(); tick();
  endtask

  task automatic op(logic sel, logic [40:0] r);
    op_valid = 1; acc_sel = sel; op_result = r; tick();
  endtask

  task automatic shift(logic [5:0] a, bit bad);
    shift_stb = 1; shift_amt = a; tick();
    chk("R5", trap_req, bad, "shift trap");
    chk("R5", cause[3], bad, "shift cause");
    clear_all();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", {trap_req, div_abort, trap_level, cause}, 0, "in reset");
    rst_n = 1; @(negedge clk);
    chk("R1", {trap_req, div_abort, trap_level, cause}, 0, "after reset");

    cur_req = "R2";
    div_start = 1; divisor = 16'd0; tick();
    chk("R2", {div_abort, trap_req, cause[0]}, 3'b111, "div by zero");
    tick();
    chk("R2", div_abort, 0, "abort one cycle");
    clear_all();
    div_start = 1; divisor = 16'd7; tick();
    chk("R2", {div_abort, trap_req, cause[0]}, 0, "nonzero divisor");

    cur_req = "R3";
    en_ovf31 = 1; en_ovf39 = 0;
    op(0, 41'h00080000000);
    chk("R3", {trap_req, cause[1]}, 2'b11, "bit31 overflow");
    clear_all();
    op(0, 41'h1FF80000000);
    chk("R3", trap_req, 0, "sign-extended negative");
    op(0, 41'h0007FFFFFFF);
    chk("R3", trap_req, 0, "max positive");
    guard_en = 1; op(1, 41'h00100000000);
    chk("R3", trap_req, 0, "guard bits in use");
    guard_en = 0; en_ovf31 = 0; op(1, 41'h00100000000);
    chk("R3", trap_req, 0, "disabled");

    cur_req = "R4";
    en_ovf39 = 1; sat_en = 0;
    op(1, 41'h10000000000);
    chk("R4", {trap_req, cause[2], cause[4]}, 3'b111, "bit39 overflow acc B");
    clear_all();
    sat_en = 1; op(0, 41'h10000000000);
    chk("R4", trap_req, 0, "saturation on");
    sat_en = 0; en_ovf39 = 0; op(0, 41'h0FFFFFFFFFF);
    chk("R4", trap_req, 0, "disabled");

    cur_req = "R5";
    shift(6'd16, 0);
    shift(6'b110000, 0);
    shift(6'd17, 1);
    shift(6'b101111, 1);
    shift(6'b100000, 1);
    shift(6'd31, 1);

    cur_req = "R7";
    div_start = 1; divisor = 0; tick();
    repeat (3) tick();
    chk("R7", cause[0], 1, "sticky hold");
    cause_clr = 1; shift_stb = 1; shift_amt = 6'd20; tick();
    chk("R7", cause[3:0], 4'b1000, "set wins over clear");
    clear_all();
    chk("R7", cause, 0, "cleared");

    cur_req = "R8";
    en_ovf31 = 1; guard_en = 0;
    op(1, 41'h00080000000);
    chk("R8", cause[4], 1, "acc B recorded");
    div_start = 1; divisor = 0; tick();
    chk("R8", cause[4], 1, "non-overflow keeps id");
    op(0, 41'h00080000000);
    chk("R8", cause[4], 0, "acc A recorded");
    op(1, 41'h00080000000);
    cause_clr = 1; tick();
    chk("R8", cause[4], 0, "clear drops id");

    cur_req = "R9";
    en_ovf39 = 1;
    op_valid = 0; op_result = 41'h10080000000; @(negedge clk); tick();
    chk("R9", {trap_req, cause}, 0, "invalid result ignored");

    cur_req = "R10";
    op_valid = 1; acc_sel = 1; op_result = 41'h10080000000;
    div_start = 1; divisor = 0; shift_stb = 1; shift_amt = 6'd40; tick();
    chk("R10", {trap_req, cause}, 6'b111111, "all at once");
    tick();
    chk("R10", trap_req, 0, "single pulse");
    clear_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule